// File: doc/BRIEF.md
# Partial-Width Register File with Deferred Merge

This block holds eight 64-bit general-purpose registers. Each register can be written and read through several views: the low byte, the second byte, the low 16 bits, the low 32 bits and the full 64 bits. A 3-bit selector and a 2-bit width code choose the view. In byte mode the selector's top bit chooses between the low byte and the second byte of registers 0 to 3, so registers 4 to 7 cannot be reached one byte at a time.

A narrow write does not update the wider value at once. The written byte or half-word lands in its own slice storage, and a per-register pending flag records that the wider views are out of date. A later read at a wider width whose flags are set lowers `rd_ready` for exactly one cycle. During that cycle the slot folds the pending slices into the wider storage. The request stays on the port, and in the next cycle it completes with the assembled value. A write of the full 32-bit or 64-bit view refreshes every slice, so no merge is owed afterwards.

There is one write port that takes effect at the clock edge, and one read port that returns data combinationally from the registered state. The read port has a request and ready handshake.

Top module: `slice_regfile`

## Requirements
- R1: Width code 0 selects a byte, 1 selects 16 bits, 2 selects 32 bits and 3 selects 64 bits. For widths 1 to 3 the selector names register 0 to 7. A read narrower than 64 bits returns its view right-aligned in `rd_data`, with all higher bits zero.
- R2: In byte mode, selector codes 0 to 3 address bits 7:0 of registers 0 to 3, and codes 4 to 7 address bits 15:8 of registers 0 to 3. A byte access never touches registers 4 to 7.
- R3: A byte write or a 16-bit write leaves every bit it does not name unchanged. A 32-bit write clears bits 63:32. A 64-bit write replaces all 64 bits.
- R4: A byte read never lowers `rd_ready`, and it returns the most recently written value of that byte.
- R5: A 16-bit read lowers `rd_ready` for one cycle exactly when a byte write has reached that register since its last write of 16 bits or wider, or since its last merge.
- R6: A 32-bit or 64-bit read lowers `rd_ready` for one cycle exactly when a byte or 16-bit write has reached that register since its last 32-bit or 64-bit write, or since its last wide merge.
- R7: After the stall cycle, a stable request with no write to that register sees `rd_ready` high and receives the merged value: the latest narrow data sits in its bit positions and the older bits are kept.
- R8: After a 32-bit or 64-bit write, reads of that register at any width complete without a stall.
- R9: When a write and a read fall in the same cycle, the read returns the register's value from before the write.
- R10: Reset clears every register to zero and clears all pending flags. After reset, reads return zero without stalling.
- R11: `rd_ready` is high in every cycle in which `rd_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write register / byte selector |
| wr_wid | input | 2 | Write width code |
| wr_data | input | 64 | Write data, right-aligned |
| rd_req | input | 1 | Read request, held until ready |
| rd_sel | input | 3 | Read register / byte selector |
| rd_wid | input | 2 | Read width code |
| rd_ready | output | 1 | Read data valid; low during a merge cycle |
| rd_data | output | 64 | Read data, zero-extended view |

## Verification
The bench builds the block with its default parameters: a 64-bit data width and a 3-bit selector. These defaults put the zero fill of bits 63:32 and the aliasing of byte codes 4 to 7 onto registers 0 to 3 within reach. Random mixes of narrow writes and wide reads reach chains of merges: a byte write followed by a 16-bit merge and then a full merge. They also reach writes that land in the merge cycle itself and cause a second stall.

// File: rtl/slice_rf_pkg.sv
package slice_rf_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned WORD_W = 32;

    // Port width code
    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } wid_e;

    // Decoded view of one access
    typedef enum logic [2:0] {
        ACC_LO8 = 3'd0,
        ACC_HI8 = 3'd1,
        ACC_16  = 3'd2,
        ACC_32  = 3'd3,
        ACC_64  = 3'd4
    } acc_e;

    // Merge request to a slot
    typedef enum logic [1:0] {
        MRG_NONE = 2'd0,
        MRG_HALF = 2'd1,
        MRG_FULL = 2'd2
    } mrg_e;

endpackage

// File: rtl/rf_port_decode.sv
module rf_port_decode
    import slice_rf_pkg::*;
#(
    parameter int unsigned SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       wid,
    output logic [SEL_W-1:0] idx,
    output acc_e             acc
);

    always_comb begin
        idx = sel;
        acc = ACC_64;
        case (wid_e'(wid))
            WID_8: begin
                // top selector bit picks the second byte of the lower half
                idx = {1'b0, sel[SEL_W-2:0]};
                acc = sel[SEL_W-1] ? ACC_HI8 : ACC_LO8;
            end
            WID_16:  acc = ACC_16;
            WID_32:  acc = ACC_32;
            default: acc = ACC_64;
        endcase
    end

endmodule

// File: rtl/rf_read_view.sv
module rf_read_view
    import slice_rf_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  acc_e              acc,
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    input  logic [HALF_W-1:0] half,
    input  logic [DATA_W-1:0] wide,
    input  logic              lo_pend,
    input  logic              hi_pend,
    input  logic              half_pend,
    output logic              need_merge,
    output mrg_e              kind,
    output logic [DATA_W-1:0] data
);

    logic byte_stale;

    always_comb begin
        byte_stale = lo_pend | hi_pend;
        need_merge = 1'b0;
        kind       = MRG_NONE;
        data       = '0;
        case (acc)
            ACC_LO8: data[BYTE_W-1:0] = lo;
            ACC_HI8: data[BYTE_W-1:0] = hi;
            ACC_16: begin
                need_merge        = byte_stale;
                kind              = byte_stale ? MRG_HALF : MRG_NONE;
                data[HALF_W-1:0]  = half;
            end
            ACC_32: begin
                need_merge        = byte_stale | half_pend;
                kind              = need_merge ? MRG_FULL : MRG_NONE;
                data[WORD_W-1:0]  = wide[WORD_W-1:0];
            end
            default: begin
                need_merge = byte_stale | half_pend;
                kind       = need_merge ? MRG_FULL : MRG_NONE;
                data       = wide;
            end
        endcase
    end

endmodule

// File: rtl/rf_slot.sv
module rf_slot
    import slice_rf_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  acc_e              wr_acc,
    input  logic [DATA_W-1:0] wr_data,
    input  mrg_e              mrg,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic [HALF_W-1:0] half,
    output logic [DATA_W-1:0] wide,
    output logic              lo_pend,
    output logic              hi_pend,
    output logic              half_pend
);

    localparam int unsigned UPPER_W = DATA_W - HALF_W;
    localparam int unsigned FILL_W  = DATA_W - WORD_W;

    typedef struct packed {
        logic [DATA_W-1:0] wide;
        logic [HALF_W-1:0] half;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              lo_pend;
        logic              hi_pend;
        logic              half_pend;
    } slot_t;

    slot_t             st_q, st_d;
    logic [HALF_W-1:0] fold_half;

    always_comb begin
        // newest 16-bit value with pending bytes folded in
        fold_half = {st_q.hi_pend ? st_q.hi : st_q.half[HALF_W-1:BYTE_W],
                     st_q.lo_pend ? st_q.lo : st_q.half[BYTE_W-1:0]};
        st_d = st_q;

        // merge first; a write in the same cycle lands on top of it
        case (mrg)
            MRG_HALF: begin
                st_d.half      = fold_half;
                st_d.lo_pend   = 1'b0;
                st_d.hi_pend   = 1'b0;
                st_d.half_pend = 1'b1;
            end
            MRG_FULL: begin
                st_d.wide      = {st_q.wide[DATA_W-1:HALF_W], fold_half};
                st_d.half      = fold_half;
                st_d.lo_pend   = 1'b0;
                st_d.hi_pend   = 1'b0;
                st_d.half_pend = 1'b0;
            end
            default: ;
        endcase

        if (wr_hit) begin
            case (wr_acc)
                ACC_LO8: begin
                    st_d.lo      = wr_data[BYTE_W-1:0];
                    st_d.lo_pend = 1'b1;
                end
                ACC_HI8: begin
                    st_d.hi      = wr_data[BYTE_W-1:0];
                    st_d.hi_pend = 1'b1;
                end
                ACC_16: begin
                    st_d.half      = wr_data[HALF_W-1:0];
                    st_d.lo        = wr_data[BYTE_W-1:0];
                    st_d.hi        = wr_data[HALF_W-1:BYTE_W];
                    st_d.lo_pend   = 1'b0;
                    st_d.hi_pend   = 1'b0;
                    st_d.half_pend = 1'b1;
                end
                default: begin
                    if (wr_acc == ACC_32)
                        st_d.wide = {{FILL_W{1'b0}}, wr_data[WORD_W-1:0]};
                    else
                        st_d.wide = wr_data;
                    st_d.half      = wr_data[HALF_W-1:0];
                    st_d.lo        = wr_data[BYTE_W-1:0];
                    st_d.hi        = wr_data[HALF_W-1:BYTE_W];
                    st_d.lo_pend   = 1'b0;
                    st_d.hi_pend   = 1'b0;
                    st_d.half_pend = 1'b0;
                end
            endcase
        end

        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lo        = st_q.lo;
    assign hi        = st_q.hi;
    assign half      = st_q.half;
    assign wide      = st_q.wide;
    assign lo_pend   = st_q.lo_pend;
    assign hi_pend   = st_q.hi_pend;
    assign half_pend = st_q.half_pend;

    // R8: a full-view write leaves nothing pending
    a_r8_wide_write_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && (wr_acc == ACC_32 || wr_acc == ACC_64))
            |=> (!st_q.lo_pend && !st_q.hi_pend && !st_q.half_pend));

    // R4: byte copies agree with the half view unless marked newer
    a_r4_byte_copy_coherent: assert property (@(posedge clk) disable iff (rst)
        (!st_q.lo_pend |-> st_q.lo == st_q.half[BYTE_W-1:0]) and
        (!st_q.hi_pend |-> st_q.hi == st_q.half[HALF_W-1:BYTE_W]));

    // R3: a 16-bit write preserves the upper part of the wide store
    a_r3_half_keeps_upper: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wr_acc == ACC_16 && mrg == MRG_NONE)
            |=> st_q.wide[DATA_W-1:HALF_W] == $past(st_q.wide[DATA_W-1:HALF_W]));

    // Unused width guard for tiny configurations
    logic unused_upper;
    assign unused_upper = (UPPER_W == 0);

endmodule

// File: rtl/slice_regfile.sv
module slice_regfile
    import slice_rf_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [1:0]        wr_wid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [1:0]        rd_wid,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned NREG = 1 << SEL_W;

    logic [SEL_W-1:0] wr_idx, rd_idx;
    acc_e             wr_acc, rd_acc;

    logic [BYTE_W-1:0] lo_v   [NREG];
    logic [BYTE_W-1:0] hi_v   [NREG];
    logic [HALF_W-1:0] half_v [NREG];
    logic [DATA_W-1:0] wide_v [NREG];
    logic [NREG-1:0]   lo_p, hi_p, half_p;

    logic  need_merge;
    mrg_e  rd_kind;
    logic [DATA_W-1:0] view_data;

    rf_port_decode #(.SEL_W(SEL_W)) u_wr_dec (
        .sel (wr_sel),
        .wid (wr_wid),
        .idx (wr_idx),
        .acc (wr_acc)
    );

    rf_port_decode #(.SEL_W(SEL_W)) u_rd_dec (
        .sel (rd_sel),
        .wid (rd_wid),
        .idx (rd_idx),
        .acc (rd_acc)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic slot_wr;
        mrg_e slot_mrg;
        assign slot_wr  = wr_en && (wr_idx == SEL_W'(g));
        assign slot_mrg = (rd_req && need_merge && rd_idx == SEL_W'(g))
                          ? rd_kind : MRG_NONE;

        rf_slot #(.DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (slot_wr),
            .wr_acc    (wr_acc),
            .wr_data   (wr_data),
            .mrg       (slot_mrg),
            .lo        (lo_v[g]),
            .hi        (hi_v[g]),
            .half      (half_v[g]),
            .wide      (wide_v[g]),
            .lo_pend   (lo_p[g]),
            .hi_pend   (hi_p[g]),
            .half_pend (half_p[g])
        );
    end

    rf_read_view #(.DATA_W(DATA_W)) u_view (
        .acc        (rd_acc),
        .lo         (lo_v[rd_idx]),
        .hi         (hi_v[rd_idx]),
        .half       (half_v[rd_idx]),
        .wide       (wide_v[rd_idx]),
        .lo_pend    (lo_p[rd_idx]),
        .hi_pend    (hi_p[rd_idx]),
        .half_pend  (half_p[rd_idx]),
        .need_merge (need_merge),
        .kind       (rd_kind),
        .data       (view_data)
    );

    assign rd_ready = !(rd_req && need_merge);
    assign rd_data  = view_data;

    // R11: an idle read port is always ready
    a_r11_idle_ready: assert property (@(posedge clk) disable iff (rst)
        !rd_req |-> rd_ready);

    // R4: byte reads never stall
    a_r4_byte_no_stall: assert property (@(posedge clk) disable iff (rst)
        (rd_req && wid_e'(rd_wid) == WID_8) |-> rd_ready);

    // R7: a merge costs one cycle when the request holds and no write hits it
    a_r7_one_cycle_merge: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ready && !(wr_en && wr_idx == rd_idx))
            |=> (rd_ready || !rd_req || !$stable(rd_sel) || !$stable(rd_wid)));

    // R1: narrow views come back zero-extended
    a_r1_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (wid_e'(rd_wid) != WID_64) |-> rd_data[DATA_W-1:WORD_W] == '0);

    // R10: the cycle after reset reads zero without a stall
    a_r10_reset_clean: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (rd_ready && rd_data == '0));

endmodule

// File: tb/slice_regfile_test.sv
`timescale 1ns/1ps
module slice_regfile_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [1:0]  wr_wid = '0;
    logic [63:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [2:0]  rd_sel = '0;
    logic [1:0]  rd_wid = '0;
    logic        rd_ready;
    logic [63:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model: architectural values and staleness marks
    logic [63:0] m_val [8];
    bit          m_lo [8];
    bit          m_hi [8];
    bit          m_h  [8];

    always #2.5 clk = ~clk;

    slice_regfile uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_wid(wr_wid), .wr_data(wr_data),
        .rd_req(rd_req), .rd_sel(rd_sel), .rd_wid(rd_wid),
        .rd_ready(rd_ready), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [2:0] s, input logic [1:0] w);
        return (w == 2'd0) ? int'(s[1:0]) : int'(s);
    endfunction

    function automatic logic [63:0] exp_view(input logic [2:0] s, input logic [1:0] w);
        logic [63:0] v;
        v = m_val[idx_of(s, w)];
        case (w)
            2'd0:    return s[2] ? {56'd0, v[15:8]} : {56'd0, v[7:0]};
            2'd1:    return {48'd0, v[15:0]};
            2'd2:    return {32'd0, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic bit exp_stall(input logic [2:0] s, input logic [1:0] w);
        int i;
        i = idx_of(s, w);
        if (w == 2'd0) return 1'b0;
        if (w == 2'd1) return m_lo[i] | m_hi[i];
        return m_lo[i] | m_hi[i] | m_h[i];
    endfunction

    task automatic model_merge(input logic [2:0] s, input logic [1:0] w);
        int i;
        i = idx_of(s, w);
        if (exp_stall(s, w)) begin
            m_lo[i] = 1'b0;
            m_hi[i] = 1'b0;
            m_h[i]  = (w == 2'd1);
        end
    endtask

    task automatic model_write(input logic [2:0] s, input logic [1:0] w,
                               input logic [63:0] d);
        int i;
        i = idx_of(s, w);
        case (w)
            2'd0: begin
                if (s[2]) begin m_val[i][15:8] = d[7:0]; m_hi[i] = 1'b1; end
                else      begin m_val[i][7:0]  = d[7:0]; m_lo[i] = 1'b1; end
            end
            2'd1: begin
                m_val[i][15:0] = d[15:0];
                m_lo[i] = 1'b0; m_hi[i] = 1'b0; m_h[i] = 1'b1;
            end
            default: begin
                m_val[i] = (w == 2'd2) ? {32'd0, d[31:0]} : d;
                m_lo[i] = 1'b0; m_hi[i] = 1'b0; m_h[i] = 1'b0;
            end
        endcase
    endtask

    task automatic do_write(input logic [2:0] s, input logic [1:0] w,
                            input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_wid = w; wr_data = d;
        @(posedge clk);
        model_write(s, w, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // read, optionally with a write in the first cycle; follows stalls
    task automatic do_read(input bit we, input logic [2:0] ws, input logic [1:0] ww,
                           input logic [63:0] wd, input logic [2:0] rs,
                           input logic [1:0] rw, input string stag,
                           input string dtag);
        bit fin;
        bit st;
        fin = 1'b0;
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_wid = ww; wr_data = wd;
        rd_req = 1'b1; rd_sel = rs; rd_wid = rw;
        for (int cyc = 0; cyc < 4 && !fin; cyc++) begin
            #1;
            st = exp_stall(rs, rw);
            chk(rd_ready == !st, stag, {63'd0, rd_ready}, {63'd0, !st});
            if (!st) begin
                chk(rd_data == exp_view(rs, rw), dtag, rd_data, exp_view(rs, rw));
                fin = 1'b1;
            end
            @(posedge clk);
            if (st) model_merge(rs, rw);
            if (wr_en) model_write(wr_sel, wr_wid, wr_data);
            @(negedge clk);
            wr_en = 1'b0;
        end
        rd_req = 1'b0;
    endtask

    task automatic do_stall_once(input logic [2:0] rs, input logic [1:0] rw,
                                 input logic [63:0] exp, input string tag);
        @(negedge clk);
        rd_req = 1'b1; rd_sel = rs; rd_wid = rw;
        #1;
        chk(rd_ready == 1'b0, {tag, " stall"}, {63'd0, rd_ready}, 64'd0);
        @(posedge clk);
        model_merge(rs, rw);
        @(negedge clk);
        #1;
        chk(rd_ready == 1'b1, "R7 ready after one cycle", {63'd0, rd_ready}, 64'd1);
        chk(rd_data == exp, "R7 merged data", rd_data, exp);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    initial begin
        repeat (1500 * 100) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_val[i] = '0; m_lo[i] = 0; m_hi[i] = 0; m_h[i] = 0;
        end
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: all registers read zero, no stall
        for (int r = 0; r < 8; r++)
            do_read(1'b0, 3'd0, 2'd0, 64'd0, 3'(r), 2'd3, "R10 ready", "R10 data");

        // R3: full write, then byte write and merges
        do_write(3'd0, 2'd3, 64'h1122_3344_5566_7788);
        do_write(3'd0, 2'd0, 64'h5);
        do_stall_once(3'd0, 2'd1, 64'h7705, "R5");
        do_stall_once(3'd0, 2'd3, 64'h1122_3344_5566_7705, "R6");

        // R8: 32-bit write zero-fills and needs no merge
        do_write(3'd0, 2'd2, 64'hFFFF_FFFF_AABB_CCDD);
        do_read(1'b0, 3'd0, 2'd0, 64'd0, 3'd0, 2'd3, "R8 ready", "R3 zero fill");
        do_read(1'b0, 3'd0, 2'd0, 64'd0, 3'd0, 2'd1, "R8 ready16", "R1 half view");

        // R2: byte code 4 is the second byte of register 0, not register 4
        do_write(3'd4, 2'd3, 64'h0123_4567_89AB_CDEF);
        do_write(3'd4, 2'd0, 64'h99);
        do_read(1'b0, 3'd0, 2'd0, 64'd0, 3'd4, 2'd0, "R4 byte no stall", "R2 high byte");
        do_read(1'b0, 3'd0, 2'd0, 64'd0, 3'd4, 2'd3, "R2 reg4 ready", "R2 reg4 untouched");
        do_stall_once(3'd0, 2'd2, 64'h0000_0000_AABB_99DD, "R6");

        // R11: idle port ready while stale data waits
        do_write(3'd1, 2'd1, 64'hBEEF);
        @(negedge clk); #1;
        chk(rd_ready == 1'b1, "R11 idle ready", {63'd0, rd_ready}, 64'd1);

        // R9: same-cycle write and read see the old value
        do_write(3'd2, 2'd3, 64'hCAFE_F00D_0000_1234);
        do_read(1'b1, 3'd2, 2'd3, 64'hDEAD_0000_0000_0000, 3'd2, 2'd3,
                "R9 ready", "R9 old value");
        do_read(1'b0, 3'd0, 2'd0, 64'd0, 3'd2, 2'd3, "R9 ready2", "R9 new value");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int unsigned kind;
            logic [2:0]  ws, rs;
            logic [1:0]  ww, rw;
            logic [63:0] wd;
            string       stag;
            kind = $urandom_range(0, 2);
            ws = 3'($urandom); ww = 2'($urandom);
            rs = 3'($urandom); rw = 2'($urandom);
            wd = {$urandom, $urandom};
            stag = (rw == 2'd0) ? "R4 rand" : (rw == 2'd1) ? "R5 rand" : "R6 rand";
            if (kind == 0) do_write(ws, ww, wd);
            else do_read(kind == 2, ws, ww, wd, rs, rw, stag, "R3 rand data");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule